// File: doc/BRIEF.md
# Receive Window Edge Pre-Aligner

This block runs once, before the main read-window centring of a byte lane. It takes the result of a single read search done with a reference pattern: for each of the eight data bits, the first passing tap seen while sweeping upward and the last passing tap seen while sweeping downward, plus one lock flag per sweep direction. When the lane's passing window sits hard against the low end of the delay range, the block raises every bit's receive deskew value. When the window sits against the high end, it raises two fixed deskew entries. It also reports the width of the lane window.

The deskew values sit in a small register file inside the block. The file has an indexed port, so they can be loaded and read back. Most entries are 5 bits wide and saturate. The two entries that the high-end correction touches carry one more bit, so that their unclamped addition cannot wrap. After a reset the block accepts one real run. Any later start request completes at once as a success and changes nothing.

The controller is a state machine. IDLE waits for `start`. On `start`, IDLE goes to FINISH when a run has already taken place since reset or when either lock flag is low. Otherwise it captures the taps and goes to EVAL. EVAL computes the window figures. It then goes to LEFT when the low-edge condition holds, to RIGHT_A when only the high-edge condition holds, and to FINISH when neither holds. LEFT steps through all entries, one per cycle. After the last entry it goes to RIGHT_A if the high-edge condition holds, and to FINISH if not. RIGHT_A updates the first fixed entry and goes to RIGHT_B. RIGHT_B updates the second fixed entry and goes to FINISH. FINISH raises `done` for one cycle and returns to IDLE.

Top module: `rx_edge_prealign`

## Requirements
- R1: When `start` is taken and `lock_up` or `lock_down` is low, the block completes with `fail`=1, `left_fix`=0, `right_fix`=0 and `win_size`=0, and leaves every deskew entry unchanged.
- R2: When the largest captured start tap is 1 or less, every deskew entry (0 to 7) is raised by 10 and clamped at 31, and `left_fix` is 1.
- R3: When the smallest captured end tap is greater than 30, deskew entries 4 and 5 are raised by 10 with no clamp, and `right_fix` is 1. These two entries are 6 bits wide and can read back values up to 41. The other entries are untouched by this step.
- R4: On a locked first run, `win_size` equals the smallest end tap minus the largest start tap plus one, taken modulo 64 (6-bit two's complement) from the taps as captured. The corrections do not affect it.
- R5: Only the first `start` after reset runs. Every later `start` completes with `fail`=0, both fix flags 0 and `win_size`=0, and changes no entry.
- R6: The two edge conditions are tested independently. When both hold, the low-edge step is applied first and the high-edge step after it. For example, entry 4 preloaded at 25 ends at 41.
- R7: `done` is high for exactly one cycle. Count the rising edges starting with the one that samples `start`. `done` is visible after edge 1 for a failed or repeated run. For a locked first run it is visible after edge 2, plus 8 edges if the low-edge step applies, plus 2 edges if the high-edge step applies.
- R8: Reset clears all deskew entries to 0. `cfg_rdata` shows entry `cfg_idx` without delay. A `cfg_we` write stores the low 5 bits of `cfg_wdata` while `busy` is 0 and is ignored while `busy` is 1.
- R9: When neither edge condition holds, both fix flags are 0 and no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one pre-alignment run (sampled in IDLE) |
| lock_up | input | 1 | Upward sweep found a lock |
| lock_down | input | 1 | Downward sweep found a lock |
| start_taps | input | 40 | Per-bit first passing tap, bit g at [5g+4:5g] |
| end_taps | input | 40 | Per-bit last passing tap, bit g at [5g+4:5g] |
| cfg_we | input | 1 | Write strobe for the deskew register file |
| cfg_idx | input | 3 | Deskew entry index for read and write |
| cfg_wdata | input | 5 | Deskew write value |
| cfg_rdata | output | 6 | Deskew value of entry `cfg_idx`, zero-extended |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Run aborted for lack of lock (valid with done) |
| left_fix | output | 1 | Low-edge correction applied (valid with done) |
| right_fix | output | 1 | High-edge correction applied (valid with done) |
| win_size | output | 6 | Lane window width (valid with done) |

## Verification
The high-edge correction is the hardest case to reach from the ports. All eight end taps must be 31 at the same time, and a uniform random draw almost never produces that. Each random run therefore picks among skewed tap profiles: all end taps forced to 31, all start taps forced to 0 or 1, both at once, or values drawn from the full range. Directed runs also sit exactly on the thresholds: a largest start of 1 against 2, and a smallest end of 30 against 31. Since the block runs only once per reset, each random run starts from a fresh reset and a random preload, and then issues a second start to confirm that the block stays quiet.

// File: rtl/rx_pa_pkg.sv
package rx_pa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_LEFT,
        ST_RIGHT_A,
        ST_RIGHT_B,
        ST_FINISH
    } pa_state_e;

endpackage

// File: rtl/rx_pa_reduce.sv
module rx_pa_reduce #(
    parameter int N        = 8,
    parameter int W        = 5,
    parameter bit FIND_MAX = 1'b1
) (
    input  logic [N*W-1:0] vals,
    output logic [W-1:0]   best
);

    logic [W-1:0] acc [N];

    assign acc[0] = vals[W-1:0];

    for (genvar g = 1; g < N; g++) begin : g_chain
        logic [W-1:0] cur;
        assign cur = vals[g*W +: W];
        if (FIND_MAX) begin : g_max
            assign acc[g] = (cur > acc[g-1]) ? cur : acc[g-1];
        end else begin : g_min
            assign acc[g] = (cur < acc[g-1]) ? cur : acc[g-1];
        end
    end

    assign best = acc[N-1];

endmodule

// File: rtl/rx_pa_deskew_rf.sv
module rx_pa_deskew_rf #(
    parameter int N      = 8,
    parameter int DSK_W  = 5,
    parameter int WIDE_W = 6,
    parameter int IDX_W  = 3,
    parameter int WIDE_A = 4,
    parameter int WIDE_B = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DSK_W-1:0]  cfg_wdata,
    output logic [WIDE_W-1:0] cfg_rdata,
    input  logic              int_we,
    input  logic [IDX_W-1:0]  int_idx,
    input  logic [WIDE_W-1:0] int_wdata,
    output logic [WIDE_W-1:0] int_rdata
);

    localparam int PAD_W = WIDE_W - DSK_W;

    logic [WIDE_W-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic hit_int;
        logic hit_cfg;
        assign hit_int = int_we && (int_idx == IDX_W'(g));
        assign hit_cfg = cfg_we && (cfg_idx == IDX_W'(g));

        if (g == WIDE_A || g == WIDE_B) begin : g_wide
            logic [WIDE_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (hit_int) begin
                    val_q <= int_wdata;
                end else if (hit_cfg) begin
                    val_q <= {{PAD_W{1'b0}}, cfg_wdata};
                end
            end
            assign ent[g] = val_q;
        end else begin : g_narrow
            logic [DSK_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (hit_int) begin
                    val_q <= int_wdata[DSK_W-1:0];
                end else if (hit_cfg) begin
                    val_q <= cfg_wdata;
                end
            end
            assign ent[g] = {{PAD_W{1'b0}}, val_q};
        end
    end

    assign cfg_rdata = ent[cfg_idx];
    assign int_rdata = ent[int_idx];

endmodule

// File: rtl/rx_pa_ctrl.sv
module rx_pa_ctrl
    import rx_pa_pkg::*;
#(
    parameter int N           = 8,
    parameter int TAP_W       = 5,
    parameter int DSK_W       = 5,
    parameter int WIDE_W      = 6,
    parameter int IDX_W       = 3,
    parameter int WIDE_A      = 4,
    parameter int WIDE_B      = 5,
    parameter int BUMP        = 10,
    parameter int LEFT_LIMIT  = 1,
    parameter int RIGHT_LIMIT = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              lock_ok,
    input  logic [TAP_W-1:0]  max_start,
    input  logic [TAP_W-1:0]  min_end,
    input  logic [WIDE_W-1:0] rd_data,
    output pa_state_e         state,
    output logic              cap_en,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WIDE_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic              left_fix,
    output logic              right_fix,
    output logic [TAP_W:0]    win_size
);

    localparam int CLAMP = (1 << DSK_W) - 1;

    pa_state_e        state_q, state_d;
    logic             used_q;
    logic [IDX_W-1:0] idx_q;
    logic             fail_q, left_q, right_q;
    logic [TAP_W:0]   win_q;
    logic             left_c, right_c, last_idx;
    logic [WIDE_W:0]  sum;

    assign left_c   = ({1'b0, max_start} <= (TAP_W+1)'(LEFT_LIMIT));
    assign right_c  = ({1'b0, min_end} > (TAP_W+1)'(RIGHT_LIMIT));
    assign last_idx = (idx_q == IDX_W'(N - 1));
    assign sum      = {1'b0, rd_data} + (WIDE_W+1)'(BUMP);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (used_q || !lock_ok) state_d = ST_FINISH;
                    else                    state_d = ST_EVAL;
                end
            end
            ST_EVAL: begin
                if (left_c)       state_d = ST_LEFT;
                else if (right_c) state_d = ST_RIGHT_A;
                else              state_d = ST_FINISH;
            end
            ST_LEFT: begin
                if (last_idx) state_d = right_q ? ST_RIGHT_A : ST_FINISH;
            end
            ST_RIGHT_A: state_d = ST_RIGHT_B;
            ST_RIGHT_B: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q  <= 1'b0;
            idx_q   <= '0;
            fail_q  <= 1'b0;
            left_q  <= 1'b0;
            right_q <= 1'b0;
            win_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        used_q  <= 1'b1;
                        fail_q  <= !used_q && !lock_ok;
                        left_q  <= 1'b0;
                        right_q <= 1'b0;
                        win_q   <= '0;
                    end
                end
                ST_EVAL: begin
                    left_q  <= left_c;
                    right_q <= right_c;
                    win_q   <= {1'b0, min_end} - {1'b0, max_start} + (TAP_W+1)'(1);
                    idx_q   <= '0;
                end
                ST_LEFT: idx_q <= idx_q + IDX_W'(1);
                default: ;
            endcase
        end
    end

    always_comb begin
        state     = state_q;
        cap_en    = (state_q == ST_IDLE) && start && !used_q && lock_ok;
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        fail      = done && fail_q;
        left_fix  = done && left_q;
        right_fix = done && right_q;
        win_size  = done ? win_q : '0;
        wr_en     = 1'b0;
        wr_idx    = idx_q;
        wr_data   = '0;
        unique case (state_q)
            ST_LEFT: begin
                wr_en   = 1'b1;
                wr_data = (sum > (WIDE_W+1)'(CLAMP)) ? WIDE_W'(CLAMP) : sum[WIDE_W-1:0];
            end
            ST_RIGHT_A: begin
                wr_en   = 1'b1;
                wr_idx  = IDX_W'(WIDE_A);
                wr_data = sum[WIDE_W-1:0];
            end
            ST_RIGHT_B: begin
                wr_en   = 1'b1;
                wr_idx  = IDX_W'(WIDE_B);
                wr_data = sum[WIDE_W-1:0];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/rx_edge_prealign.sv
module rx_edge_prealign
    import rx_pa_pkg::*;
#(
    parameter int NBITS       = 8,
    parameter int TAP_W       = 5,
    parameter int DSK_W       = 5,
    parameter int HEAD_W      = 1,
    parameter int WIDE_A      = 4,
    parameter int WIDE_B      = 5,
    parameter int BUMP        = 10,
    parameter int LEFT_LIMIT  = 1,
    parameter int RIGHT_LIMIT = 30
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     lock_up,
    input  logic                     lock_down,
    input  logic [NBITS*TAP_W-1:0]   start_taps,
    input  logic [NBITS*TAP_W-1:0]   end_taps,
    input  logic                     cfg_we,
    input  logic [$clog2(NBITS)-1:0] cfg_idx,
    input  logic [DSK_W-1:0]         cfg_wdata,
    output logic [DSK_W+HEAD_W-1:0]  cfg_rdata,
    output logic                     busy,
    output logic                     done,
    output logic                     fail,
    output logic                     left_fix,
    output logic                     right_fix,
    output logic [TAP_W:0]           win_size
);

    localparam int IDX_W  = $clog2(NBITS);
    localparam int WIDE_W = DSK_W + HEAD_W;

    pa_state_e          st;
    logic               cap_en;
    logic [NBITS*TAP_W-1:0] start_q, end_q;
    logic [TAP_W-1:0]   max_start, min_end;
    logic               int_we;
    logic [IDX_W-1:0]   int_idx;
    logic [WIDE_W-1:0]  int_wdata, int_rdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            end_q   <= '0;
        end else if (cap_en) begin
            start_q <= start_taps;
            end_q   <= end_taps;
        end
    end

    rx_pa_reduce #(.N(NBITS), .W(TAP_W), .FIND_MAX(1'b1)) i_max_start (
        .vals (start_q),
        .best (max_start)
    );

    rx_pa_reduce #(.N(NBITS), .W(TAP_W), .FIND_MAX(1'b0)) i_min_end (
        .vals (end_q),
        .best (min_end)
    );

    rx_pa_ctrl #(
        .N(NBITS), .TAP_W(TAP_W), .DSK_W(DSK_W), .WIDE_W(WIDE_W), .IDX_W(IDX_W),
        .WIDE_A(WIDE_A), .WIDE_B(WIDE_B), .BUMP(BUMP),
        .LEFT_LIMIT(LEFT_LIMIT), .RIGHT_LIMIT(RIGHT_LIMIT)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lock_ok   (lock_up && lock_down),
        .max_start (max_start),
        .min_end   (min_end),
        .rd_data   (int_rdata),
        .state     (st),
        .cap_en    (cap_en),
        .wr_en     (int_we),
        .wr_idx    (int_idx),
        .wr_data   (int_wdata),
        .busy      (busy),
        .done      (done),
        .fail      (fail),
        .left_fix  (left_fix),
        .right_fix (right_fix),
        .win_size  (win_size)
    );

    rx_pa_deskew_rf #(
        .N(NBITS), .DSK_W(DSK_W), .WIDE_W(WIDE_W), .IDX_W(IDX_W),
        .WIDE_A(WIDE_A), .WIDE_B(WIDE_B)
    ) i_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we && !busy),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .int_we    (int_we),
        .int_idx   (int_idx),
        .int_wdata (int_wdata),
        .int_rdata (int_rdata)
    );

endmodule

// File: rtl/rx_pa_checker.sv
module rx_pa_checker
    import rx_pa_pkg::*;
#(
    parameter int DSK_W  = 5,
    parameter int WIDE_W = 6,
    parameter int WIN_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              fail,
    input logic              left_fix,
    input logic              right_fix,
    input logic              busy,
    input logic [WIN_W-1:0]  win_size,
    input pa_state_e         st,
    input logic              wr_en,
    input logic [WIDE_W-1:0] wr_data
);

    localparam int CLAMP = (1 << DSK_W) - 1;

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    seen_q <= 1'b0;
        else if (done) seen_q <= 1'b1;
    end

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fail_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> (!left_fix && !right_fix && win_size == '0));

    p_repeat_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && seen_q) |-> (!fail && !left_fix && !right_fix && win_size == '0));

    p_left_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st == ST_LEFT) |-> (wr_data <= WIDE_W'(CLAMP)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (st == ST_RIGHT_A || st == ST_RIGHT_B)) |-> (wr_data >= WIDE_W'(10)));

    p_write_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);

endmodule

bind rx_edge_prealign rx_pa_checker #(
    .DSK_W(DSK_W), .WIDE_W(DSK_W + HEAD_W), .WIN_W(TAP_W + 1)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .fail      (fail),
    .left_fix  (left_fix),
    .right_fix (right_fix),
    .busy      (busy),
    .win_size  (win_size),
    .st        (st),
    .wr_en     (int_we),
    .wr_data   (int_wdata)
);

// File: tb/test_rx_edge_prealign.sv
`timescale 1ns/1ps
module test_rx_edge_prealign;

    localparam int NB = 8;
    localparam int TW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          lock_up = 1'b0, lock_down = 1'b0;
    logic [NB*TW-1:0] start_taps = '0, end_taps = '0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_idx = '0;
    logic [4:0]    cfg_wdata = '0;
    logic [5:0]    cfg_rdata;
    logic          busy, done, fail, left_fix, right_fix;
    logic [5:0]    win_size;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;
    bit finished = 0;
    int model [NB];

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles++;

    rx_edge_prealign i_rx_edge_prealign (
        .clk(clk), .rst_n(rst_n), .start(start), .lock_up(lock_up), .lock_down(lock_down),
        .start_taps(start_taps), .end_taps(end_taps), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done), .fail(fail),
        .left_fix(left_fix), .right_fix(right_fix), .win_size(win_size)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int max_start_f(input logic [NB*TW-1:0] v);
        int m = 0;
        for (int g = 0; g < NB; g++) if (int'(v[g*TW +: TW]) > m) m = int'(v[g*TW +: TW]);
        return m;
    endfunction

    function automatic int min_end_f(input logic [NB*TW-1:0] v);
        int m = 31;
        for (int g = 0; g < NB; g++) if (int'(v[g*TW +: TW]) < m) m = int'(v[g*TW +: TW]);
        return m;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) model[i] = 0;
    endtask

    task automatic preload(input bit rnd, input int v);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            cfg_we = 1'b1;
            cfg_idx = 3'(i);
            cfg_wdata = rnd ? 5'($urandom_range(0, 31)) : 5'(v);
            model[i] = int'(cfg_wdata);
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_rf(input string req);
        for (int i = 0; i < NB; i++) begin
            cfg_idx = 3'(i);
            #0.1;
            chk(int'(cfg_rdata) == model[i], req, $sformatf("entry %0d", i), int'(cfg_rdata), model[i]);
        end
    endtask

    // first: expected a real run; poke: attempt a cfg write to entry 2 while busy
    task automatic run(input bit first, input bit poke, input string req);
        bit lk, l, r;
        int exp_lat, exp_win, n;
        lk = lock_up && lock_down;
        l = max_start_f(start_taps) <= 1;
        r = min_end_f(end_taps) > 30;
        exp_win = first && lk ? ((min_end_f(end_taps) - max_start_f(start_taps) + 1) & 63) : 0;
        exp_lat = (!first || !lk) ? 1 : (2 + (l ? 8 : 0) + (r ? 2 : 0));
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        n = 1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            cfg_we = 1'b1; cfg_idx = 3'd2; cfg_wdata = 5'd17;
        end
        while (!done && n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        cfg_we = 1'b0;
        chk(n == exp_lat, "R7", "done latency", n, exp_lat);
        chk(fail == (first && !lk), "R1", "fail", int'(fail), int'(first && !lk));
        chk(left_fix == (first && lk && l), "R2", "left_fix", int'(left_fix), int'(first && lk && l));
        chk(right_fix == (first && lk && r), "R3", "right_fix", int'(right_fix), int'(first && lk && r));
        chk(int'(win_size) == exp_win, "R4", "win_size", int'(win_size), exp_win);
        if (first && lk) begin
            if (l) for (int i = 0; i < NB; i++) model[i] = (model[i] + 10 > 31) ? 31 : model[i] + 10;
            if (r) begin
                model[4] += 10;
                model[5] += 10;
            end
        end
        check_rf(req);
        @(posedge clk);
        #0.1;
        chk(done == 1'b0, "R7", "done one cycle", int'(done), 0);
    endtask

    task automatic set_taps(input int smin, input int smax, input int emin, input int emax);
        for (int g = 0; g < NB; g++) begin
            start_taps[g*TW +: TW] = TW'($urandom_range(smax, smin));
            end_taps[g*TW +: TW]   = TW'($urandom_range(emax, emin));
        end
    endtask

    initial begin
        while (cycles < 150000 && !finished) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        #0.1;
        chk(done == 1'b0 && busy == 1'b0, "R8", "idle after reset", int'({done, busy}), 0);
        check_rf("R8");

        // R1: lock missing
        preload(1, 0);
        lock_up = 1'b1; lock_down = 1'b0;
        set_taps(0, 1, 31, 31);
        run(1, 0, "R1");
        run(0, 0, "R5");

        // R2: left edge, with boundary max start = 1; cfg poke while busy ignored (R8)
        do_reset();
        preload(0, 28);
        lock_up = 1; lock_down = 1;
        set_taps(0, 1, 10, 20);
        start_taps[3*TW +: TW] = 5'd1;
        run(1, 1, "R2");

        // R9: max start = 2, min end = 30: no correction
        do_reset();
        preload(1, 0);
        set_taps(2, 2, 30, 31);
        end_taps[0 +: TW] = 5'd30;
        run(1, 0, "R9");

        // R3: right edge only, entries 4 and 5 at 31 go to 41
        do_reset();
        preload(0, 31);
        set_taps(2, 9, 31, 31);
        run(1, 0, "R3");
        run(0, 0, "R5");

        // R6: both edges; entry 4 preloaded 25 -> 31 -> 41
        do_reset();
        preload(1, 0);
        @(negedge clk);
        cfg_we = 1; cfg_idx = 3'd4; cfg_wdata = 5'd25; model[4] = 25;
        @(negedge clk);
        cfg_we = 0;
        set_taps(0, 0, 31, 31);
        run(1, 0, "R6");
        chk(model[4] == 41, "R6", "model entry 4", model[4], 41);

        // random runs with skewed tap profiles
        for (int it = 0; it < 150; it++) begin
            int prof;
            do_reset();
            preload(1, 0);
            prof = $urandom_range(0, 3);
            case (prof)
                0: set_taps(0, 1, 5, 31);
                1: set_taps(0, 15, 31, 31);
                2: set_taps(0, 1, 31, 31);
                default: set_taps(0, 31, 0, 31);
            endcase
            lock_up = ($urandom_range(0, 7) != 0);
            lock_down = ($urandom_range(0, 7) != 0);
            run(1, $urandom_range(0, 1) == 1, "R4");
            set_taps(0, 1, 31, 31);
            lock_up = 1; lock_down = 1;
            run(0, 0, "R5");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule